// File: doc/BRIEF.md
# Two-Channel Timer with 32-bit Cascade

The block holds two 16-bit counting channels, an upper one and a lower one. A small register write port sets each channel's clock source, counting mode and capture edge. It also sets the run bits and lets software preload either counter. The two channels can count on their own. They can also be joined into a single 32-bit counter, with the upper channel taking the lower channel's wrap events as its count source.

The lower channel counts a tap of a shared prescaler. In phase counting mode it instead follows a two-phase quadrature pair, so it can count in both directions. When the lower half wraps upward, the upper half gains one. When it wraps downward, which only happens in phase counting mode, the upper half loses one. Both halves change on the same clock edge.

If the upper channel is itself put in phase counting mode, it follows its own quadrature pins and disregards both its clock select and the cascade. Each channel has a capture register that loads on a chosen edge of its capture pin. A common edge on both capture pins therefore records a consistent 32-bit snapshot.

Top module: `casc_timer32`

## Requirements
- R1: After reset, both counters and both capture registers read 0, and both channels are stopped.
- R2: The write port decodes `wr_addr` as follows. 0 is upper control and 1 is lower control; both use the fields [2:0] clock select, [3] phase mode and [5:4] capture edge. 2 holds the run bits: [0] upper, [1] lower. A write to 3 loads the upper counter and a write to 4 loads the lower counter. A load takes effect on the write edge and overrides any count in that cycle.
- R3: A channel whose run bit is 0 holds its count. This includes the upper channel when a lower-half wrap arrives.
- R4: Outside phase mode, clock select 000 counts every cycle, 001 every 4th cycle, 010 every 16th and 011 every 64th. Every other code counts every cycle, and that includes 111 on the lower channel.
- R5: With upper clock select 111 and the upper channel not in phase mode, a lower-half wrap from 0xFFFF to 0x0000 adds one to the upper half on the same edge.
- R6: A lower-half wrap from 0x0000 to 0xFFFF subtracts one from the upper half on the same edge. It can occur only in phase mode.
- R7: In phase mode, a channel decodes its pins (A, B) in 4x quadrature. The cycle 00→10→11→01→00 (A leading) counts up and the reverse counts down. A change on both pins in one sampled step is ignored. The count changes on the third rising clock edge after a pin change.
- R8: An upper channel in phase mode ignores its clock select and the cascade, and counts its own pins.
- R9: Capture edge code 00 disables capture, 01 selects rising, 10 falling and 11 both edges. The capture register takes the counter value from before that cycle's update, on the third rising clock edge after the pin change.
- R10: Rising edges on both capture pins in the same cycle store the upper half in the upper capture register and the lower half in the lower capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| hi_pin_a | input | 1 | Upper channel phase A |
| hi_pin_b | input | 1 | Upper channel phase B |
| lo_pin_a | input | 1 | Lower channel phase A |
| lo_pin_b | input | 1 | Lower channel phase B |
| hi_cap_pin | input | 1 | Upper channel capture pin |
| lo_cap_pin | input | 1 | Lower channel capture pin |
| cnt_hi | output | 16 | Upper counter |
| cnt_lo | output | 16 | Lower counter |
| capt_hi | output | 16 | Upper capture register |
| capt_lo | output | 16 | Lower capture register |

## Verification
The bench builds the block with its defaults:
- 16-bit counters.
- Two-stage synchronizers.
- A prescaler step of 2, giving taps at 1, 4, 16 and 64.

With the 16-bit width, preloading values next to 0xFFFF and 0x0000 puts both wrap directions within a few quadrature steps. With the step of 2, each divided tap can be measured exactly over a single 64-cycle window, whatever the prescaler phase. With the two synchronizer stages, every pin response lands on a fixed third edge that the bench waits out.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int ADDR_W   = 3;
  localparam int PRE_TAPS = 4;
  localparam int SEL_SPAN = 8;

  typedef struct packed {
    logic [1:0] cap_edge;  // [5:4] 01 rise, 10 fall, 11 both
    logic       phase;     // [3]   quadrature mode
    logic [2:0] clk_sel;   // [2:0] prescaler tap / cascade
  } ch_ctrl_t;

  localparam int CTRL_W = $bits(ch_ctrl_t);

  localparam logic [ADDR_W-1:0] A_CTRL_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_RUN     = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOAD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_LOAD_LO = 3'd4;

  localparam logic [2:0] CSEL_CASCADE = 3'b111;
endpackage

// File: rtl/ct_sync.sv
module ct_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int TAPS = 4,
  parameter int STEP = 2
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TAPS-1:0] tick
);
  localparam int PW = STEP * (TAPS - 1);

  logic [PW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) div_cnt <= '0;
    else     div_cnt <= div_cnt + 1'b1;
  end

  assign tick[0] = 1'b1;
  for (genvar g = 1; g < TAPS; g++) begin : g_tap
    assign tick[g] = &div_cnt[STEP*g-1:0];
  end
endmodule

// File: rtl/ct_quad.sv
module ct_quad #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_a,
  input  logic pin_b,
  output logic step_up,
  output logic step_dn
);
  logic [1:0] ab_s, ab_prev;
  logic a_chg, b_chg, one_chg, fwd;

  ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({pin_a, pin_b}), .q(ab_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ab_prev <= '0;
    else     ab_prev <= ab_s;
  end

  assign a_chg   = ab_s[1] ^ ab_prev[1];
  assign b_chg   = ab_s[0] ^ ab_prev[0];
  assign one_chg = a_chg ^ b_chg;
  // A leading B: A moves to differ from B, or B moves to match A
  assign fwd     = a_chg ? (ab_s[1] != ab_s[0]) : (ab_s[1] == ab_s[0]);
  assign step_up = one_chg & fwd;
  assign step_dn = one_chg & ~fwd;

  // R7: a step in either direction only follows a single-pin change
  p_step_needs_change_r7: assert property (@(posedge clk) disable iff (rst)
    (step_up || step_dn) |-> (ab_s != ab_prev) && !(a_chg && b_chg));
endmodule

// File: rtl/ct_channel.sv
module ct_channel #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  input  logic             dec,
  input  logic             cap_pin,
  input  logic [1:0]       cap_edge,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] capt,
  output logic             wrap_up,
  output logic             wrap_dn
);
  logic cap_s, cap_prev, rise, fall, cap_fire;
  logic go_up, go_dn;

  ct_sync #(.W(1), .STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst(rst), .d(cap_pin), .q(cap_s)
  );

  always_ff @(posedge clk) begin
    if (rst) cap_prev <= 1'b0;
    else     cap_prev <= cap_s;
  end

  assign rise     = cap_s & ~cap_prev;
  assign fall     = ~cap_s & cap_prev;
  assign cap_fire = (cap_edge[0] & rise) | (cap_edge[1] & fall);

  assign go_up   = run & ~load_en & inc & ~dec;
  assign go_dn   = run & ~load_en & dec & ~inc;
  assign wrap_up = go_up & (cnt == '1);
  assign wrap_dn = go_dn & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (load_en) cnt <= load_val;
    else if (go_up)   cnt <= cnt + 1'b1;
    else if (go_dn)   cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           capt <= '0;
    else if (cap_fire) capt <= cnt;
  end

  p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_en) |=> $stable(cnt));

  p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (cnt == $past(load_val)));

  p_capture_old_value_r9: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> (capt == $past(cnt)));

  p_no_capture_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    (cap_edge == 2'b00) |=> $stable(capt));
endmodule

// File: rtl/casc_timer32.sv
module casc_timer32 #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_STEP    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ct_pkg::ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]          wr_data,
  input  logic                      hi_pin_a,
  input  logic                      hi_pin_b,
  input  logic                      lo_pin_a,
  input  logic                      lo_pin_b,
  input  logic                      hi_cap_pin,
  input  logic                      lo_cap_pin,
  output logic [CNT_W-1:0]          cnt_hi,
  output logic [CNT_W-1:0]          cnt_lo,
  output logic [CNT_W-1:0]          capt_hi,
  output logic [CNT_W-1:0]          capt_lo
);
  import ct_pkg::*;

  ch_ctrl_t ctrl_hi, ctrl_lo;
  logic     run_hi, run_lo;
  logic     ld_hi, ld_lo;
  logic [PRE_TAPS-1:0] tick;
  logic [SEL_SPAN-1:0] tick_ext;
  logic hq_up, hq_dn, lq_up, lq_dn;
  logic hi_inc, hi_dec, lo_inc, lo_dec;
  logic lo_wrap_up, lo_wrap_dn, hi_wrap_up, hi_wrap_dn;
  logic hi_cascade;

  // register write port
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_hi <= '0;
      ctrl_lo <= '0;
      run_hi  <= 1'b0;
      run_lo  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL_HI: ctrl_hi <= ch_ctrl_t'(wr_data[CTRL_W-1:0]);
        A_CTRL_LO: ctrl_lo <= ch_ctrl_t'(wr_data[CTRL_W-1:0]);
        A_RUN: begin
          run_hi <= wr_data[0];
          run_lo <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  assign ld_hi = wr_en && (wr_addr == A_LOAD_HI);
  assign ld_lo = wr_en && (wr_addr == A_LOAD_LO);

  ct_prescaler #(.TAPS(PRE_TAPS), .STEP(PRE_STEP)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );
  // codes past the last tap fall back to every cycle
  assign tick_ext = {{(SEL_SPAN-PRE_TAPS){1'b1}}, tick};

  ct_quad #(.SYNC_STAGES(SYNC_STAGES)) u_quad_hi (
    .clk(clk), .rst(rst), .pin_a(hi_pin_a), .pin_b(hi_pin_b),
    .step_up(hq_up), .step_dn(hq_dn)
  );
  ct_quad #(.SYNC_STAGES(SYNC_STAGES)) u_quad_lo (
    .clk(clk), .rst(rst), .pin_a(lo_pin_a), .pin_b(lo_pin_b),
    .step_up(lq_up), .step_dn(lq_dn)
  );

  // lower channel source
  always_comb begin
    if (ctrl_lo.phase) begin
      lo_inc = lq_up;
      lo_dec = lq_dn;
    end else begin
      lo_inc = tick_ext[ctrl_lo.clk_sel];
      lo_dec = 1'b0;
    end
  end

  // upper channel source: phase mode overrides the clock select
  assign hi_cascade = !ctrl_hi.phase && (ctrl_hi.clk_sel == CSEL_CASCADE);

  always_comb begin
    if (ctrl_hi.phase) begin
      hi_inc = hq_up;
      hi_dec = hq_dn;
    end else if (hi_cascade) begin
      hi_inc = lo_wrap_up;
      hi_dec = lo_wrap_dn;
    end else begin
      hi_inc = tick_ext[ctrl_hi.clk_sel];
      hi_dec = 1'b0;
    end
  end

  ct_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch_lo (
    .clk(clk), .rst(rst), .run(run_lo), .load_en(ld_lo), .load_val(wr_data),
    .inc(lo_inc), .dec(lo_dec), .cap_pin(lo_cap_pin), .cap_edge(ctrl_lo.cap_edge),
    .cnt(cnt_lo), .capt(capt_lo), .wrap_up(lo_wrap_up), .wrap_dn(lo_wrap_dn)
  );

  ct_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch_hi (
    .clk(clk), .rst(rst), .run(run_hi), .load_en(ld_hi), .load_val(wr_data),
    .inc(hi_inc), .dec(hi_dec), .cap_pin(hi_cap_pin), .cap_edge(ctrl_hi.cap_edge),
    .cnt(cnt_hi), .capt(capt_hi), .wrap_up(hi_wrap_up), .wrap_dn(hi_wrap_dn)
  );

  p_cascade_up_r5: assert property (@(posedge clk) disable iff (rst)
    (hi_cascade && lo_wrap_up && run_hi && !ld_hi)
      |=> (cnt_hi == $past(cnt_hi) + 1'b1) && (cnt_lo == '0));

  p_cascade_dn_r6: assert property (@(posedge clk) disable iff (rst)
    (hi_cascade && lo_wrap_dn && run_hi && !ld_hi)
      |=> (cnt_hi == $past(cnt_hi) - 1'b1) && (cnt_lo == '1));

  p_no_underflow_outside_phase_r6: assert property (@(posedge clk) disable iff (rst)
    !ctrl_lo.phase |-> !lo_wrap_dn);

  p_phase_hi_ignores_cascade_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hi.phase && !hq_up && !hq_dn && !ld_hi) |=> $stable(cnt_hi));

  p_stopped_hi_ignores_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_hi && !ld_hi && (lo_wrap_up || lo_wrap_dn)) |=> $stable(cnt_hi));

  p_upper_wrap_unused_r5: assert property (@(posedge clk) disable iff (rst)
    hi_wrap_up |=> (cnt_hi == '0));

  p_upper_wrap_dn_unused_r6: assert property (@(posedge clk) disable iff (rst)
    hi_wrap_dn |=> (cnt_hi == '1));
endmodule

// File: tb/casc_timer32_bench.sv
module casc_timer32_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic hi_pin_a = 0, hi_pin_b = 0, lo_pin_a = 0, lo_pin_b = 0;
  logic hi_cap_pin = 0, lo_cap_pin = 0;
  logic [W-1:0] cnt_hi, cnt_lo, capt_hi, capt_lo;

  casc_timer32 u_casc_timer32 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hi_pin_a(hi_pin_a), .hi_pin_b(hi_pin_b), .lo_pin_a(lo_pin_a), .lo_pin_b(lo_pin_b),
    .hi_cap_pin(hi_cap_pin), .lo_cap_pin(lo_cap_pin),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .capt_hi(capt_hi), .capt_lo(capt_lo)
  );

  typedef struct {
    string        req;
    int           sel;
    logic [W-1:0] exp;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  int   lo_idx = 0, hi_idx = 0;

  function automatic logic [W-1:0] observe(int sel);
    case (sel)
      0:       return cnt_hi;
      1:       return cnt_lo;
      2:       return capt_hi;
      default: return capt_lo;
    endcase
  endfunction

  function automatic string oname(int sel);
    case (sel)
      0:       return "cnt_hi";
      1:       return "cnt_lo";
      2:       return "capt_hi";
      default: return "capt_lo";
    endcase
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t it;
        logic [W-1:0] act;
        it  = q.pop_front();
        act = observe(it.sel);
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s actual %h expected %h", it.req, oname(it.sel), act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, int sel, logic [W-1:0] v);
    q.push_back('{req, sel, v});
    ->chk_ev;
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] ab(logic [1:0] i);
    case (i)
      2'd0: return 2'b00;
      2'd1: return 2'b10;
      2'd2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic step_lo(int d);
    logic [1:0] p;
    lo_idx += d;
    p = ab(lo_idx[1:0]);
    lo_pin_a = p[1]; lo_pin_b = p[0];
    idle(4);
  endtask

  task automatic step_hi(int d);
    logic [1:0] p;
    hi_idx += d;
    p = ab(hi_idx[1:0]);
    hi_pin_a = p[1]; hi_pin_b = p[0];
    idle(4);
  endtask

  task automatic measure_div(logic [2:0] sel, int per64, string tag);
    logic [W-1:0] v0;
    wr(3'd1, {13'd0, sel});
    wr(3'd4, 16'h0000);
    wr(3'd2, 16'h0002);
    idle(3);
    v0 = cnt_lo;
    idle(64);
    expect_val(tag, 1, v0 + W'(per64));
    wr(3'd2, 16'h0000);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    expect_val("R1", 0, 16'h0000);
    expect_val("R1", 1, 16'h0000);
    expect_val("R1", 2, 16'h0000);
    expect_val("R1", 3, 16'h0000);

    // R3: lower selected at every cycle but not started
    wr(3'd1, 16'h0000);
    idle(10);
    expect_val("R3", 1, 16'h0000);

    // R2 loads, then R5 cascade overflow: 5 counts from FFFE
    wr(3'd3, 16'h0005);
    wr(3'd4, 16'hFFFE);
    expect_val("R2", 0, 16'h0005);
    expect_val("R2", 1, 16'hFFFE);
    wr(3'd0, 16'h0007);
    wr(3'd2, 16'h0003);
    idle(4);
    wr(3'd2, 16'h0000);
    expect_val("R5", 1, 16'h0003);
    expect_val("R5", 0, 16'h0006);

    // R3: same run with the upper channel stopped
    wr(3'd3, 16'h0005);
    wr(3'd4, 16'hFFFE);
    wr(3'd2, 16'h0002);
    idle(4);
    wr(3'd2, 16'h0000);
    expect_val("R3", 1, 16'h0003);
    expect_val("R3", 0, 16'h0005);

    // R4: unlisted code 101 counts every cycle (10 counts)
    wr(3'd1, 16'h0005);
    wr(3'd4, 16'h0000);
    wr(3'd2, 16'h0002);
    idle(9);
    wr(3'd2, 16'h0000);
    expect_val("R4", 1, 16'h000A);

    // R4: divided taps over a 64-cycle window
    measure_div(3'b001, 16, "R4 div4");
    measure_div(3'b010, 4,  "R4 div16");
    measure_div(3'b011, 1,  "R4 div64");

    // R6/R7: lower in phase mode, underflow borrows from upper
    wr(3'd1, 16'h0008);
    wr(3'd0, 16'h0007);
    wr(3'd4, 16'h0001);
    wr(3'd3, 16'h0007);
    wr(3'd2, 16'h0003);
    step_lo(-1); step_lo(-1); step_lo(-1);
    expect_val("R7 down", 1, 16'hFFFE);
    expect_val("R6", 0, 16'h0006);
    step_lo(1); step_lo(1); step_lo(1); step_lo(1);
    expect_val("R7 up", 1, 16'h0002);
    expect_val("R5 quad", 0, 16'h0007);

    // R7: both pins flip together, ignored
    lo_idx += 2;
    begin
      logic [1:0] p;
      p = ab(lo_idx[1:0]);
      lo_pin_a = p[1]; lo_pin_b = p[0];
    end
    idle(5);
    expect_val("R7 both", 1, 16'h0002);

    // R8: upper in phase mode with clock select 111
    wr(3'd0, 16'h000F);
    wr(3'd4, 16'hFFFF);
    step_lo(1);
    expect_val("R8", 1, 16'h0000);
    expect_val("R8", 0, 16'h0007);
    step_hi(1); step_hi(1);
    expect_val("R8", 0, 16'h0009);
    wr(3'd2, 16'h0000);

    // R10: simultaneous rising capture edges
    wr(3'd0, 16'h0010);
    wr(3'd1, 16'h0010);
    wr(3'd3, 16'h1234);
    wr(3'd4, 16'hABCD);
    hi_cap_pin = 1'b1; lo_cap_pin = 1'b1;
    idle(4);
    expect_val("R10", 2, 16'h1234);
    expect_val("R10", 3, 16'hABCD);
    hi_cap_pin = 1'b0; lo_cap_pin = 1'b0;
    idle(4);

    // R9: falling-only ignores the rising edge, takes the falling one
    wr(3'd1, 16'h0020);
    wr(3'd4, 16'h1111);
    lo_cap_pin = 1'b1;
    idle(4);
    expect_val("R9 rise ignored", 3, 16'hABCD);
    lo_cap_pin = 1'b0;
    idle(4);
    expect_val("R9 fall", 3, 16'h1111);

    // R9: capture off
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h2222);
    hi_cap_pin = 1'b1; idle(4);
    hi_cap_pin = 1'b0; idle(4);
    expect_val("R9 off", 2, 16'h1234);

    // R9: both edges
    wr(3'd1, 16'h0030);
    wr(3'd4, 16'h3333);
    lo_cap_pin = 1'b1; idle(4);
    expect_val("R9 both rise", 3, 16'h3333);
    wr(3'd4, 16'h4444);
    lo_cap_pin = 1'b0; idle(4);
    expect_val("R9 both fall", 3, 16'h4444);

    idle(2);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule